// File: doc/BRIEF.md
# Masked Data-Value Break Comparator

This block is a debug trigger that watches the operand bus of a processor. For every access it is strobed with, it compares the data value against a programmed 32-bit compare word under a programmed 32-bit mask. When the comparison succeeds, it raises a one-clock break-match pulse. Software or a debug agent loads the compare word and the mask through a small register port, and can read either one back.

The access size sets which bits of the bus take part. A byte access uses bits [7:0] and a word access uses bits [15:0]. A longword access uses bits [31:0]. A quadword access checks the upper and lower 32-bit halves of the 64-bit bus separately against the same compare and mask pair, and a hit in either half is enough. Cache-maintenance accesses arrive with the carries-data flag low, and they never produce a data match. An enable pin switches the data condition on. When the enable is low, every strobe reports a match, so that an address comparator elsewhere decides alone.

The access strobe is a plain single-cycle valid with no ready: the block takes one access every cycle and applies no back-pressure. The compare and mask registers have no reset value, so they must be written before the enable is set.

Top module: `data_break_cmp`

## Requirements
- R1: A mask bit at 1 removes the matching compare bit from the condition, and a mask bit at 0 keeps it in.
- R2: `reg_sel` = 0 addresses the compare register and `reg_sel` = 1 addresses the mask register. `reg_rdata` shows the last value written to the selected register.
- R3: Size code 2'b00 (byte) compares only bus bits [7:0] with compare bits [7:0]. Higher bits of the bus and of the compare word have no effect.
- R4: Size code 2'b01 (word) compares bus bits [15:0] with compare bits [15:0]. Bits [31:16] have no effect.
- R5: Size code 2'b10 (longword) compares all of bus bits [31:0]. Bus bits [63:32] have no effect.
- R6: Size code 2'b11 (quadword) matches when bus bits [31:0] or bus bits [63:32] satisfy the masked compare.
- R7: With `cmp_en` high and `acc_has_data` low, a strobe never produces a match.
- R8: With `cmp_en` low, every strobe produces a match, whatever the data and the registers hold.
- R9: `brk_match` is registered. It is high for exactly the one cycle after a qualifying strobe, and it is low in the cycle after a cycle with no strobe. It is low after reset.
- R10: A register write takes effect for strobes in later cycles. A strobe in the same cycle as a write is judged against the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the compare register, 1 selects the mask register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| cmp_en | input | 1 | Enables the data condition |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_size | input | 2 | 00 byte, 01 word, 10 longword, 11 quadword |
| acc_has_data | input | 1 | The access carries a data value |
| acc_data | input | 64 | Operand data bus |
| brk_match | output | 1 | Break-match pulse |

## Verification
A register write and an access strobe can fall in the same cycle. Their ordering decides whether the access sees the old or the new compare word. The bench provokes this by rewriting the compare register on the very cycle it strobes an access whose data equals only the old value, and it expects a match. The next strobe carries data equal to the new value and is also expected to match, while a strobe that still carries the old value is expected not to match.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_QUAD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/dbc_regs.sv
module dbc_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cmp_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] rdata
);
  // Contents are undefined until written; no reset on purpose.
  always_ff @(posedge clk) begin
    if (wr_en && !wr_sel) cmp_q  <= wdata;
    if (wr_en &&  wr_sel) mask_q <= wdata;
  end

  assign rdata = wr_sel ? mask_q : cmp_q;
endmodule

// File: rtl/dbc_half_cmp.sv
module dbc_half_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] word,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] lane_en,
  output logic         hit
);
  logic [W-1:0] diff;
  assign diff = (word ^ cmp) & ~mask & lane_en;
  assign hit  = (diff == '0);
endmodule

// File: rtl/data_break_cmp.sv
module data_break_cmp #(
  parameter int DATA_W = 32,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr_en,
  input  logic                    reg_sel,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic                    cmp_en,
  input  logic                    acc_valid,
  input  logic [1:0]              acc_size,
  input  logic                    acc_has_data,
  input  logic [DATA_W*LANES-1:0] acc_data,
  output logic                    brk_match
);
  import dbc_pkg::*;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  logic [DATA_W-1:0] cmp_q, mask_q, lane_en;
  logic [LANES-1:0]  half_hit;
  logic              data_hit, cond, match_q;
  acc_size_e         size;

  dbc_regs #(.W(DATA_W)) u_regs (
    .clk    (clk),
    .wr_en  (reg_wr_en),
    .wr_sel (reg_sel),
    .wdata  (reg_wdata),
    .cmp_q  (cmp_q),
    .mask_q (mask_q),
    .rdata  (reg_rdata)
  );

  assign size = acc_size_e'(acc_size);

  always_comb begin
    unique case (size)
      SZ_BYTE: lane_en = DATA_W'({BYTE_W{1'b1}});
      SZ_WORD: lane_en = DATA_W'({WORD_W{1'b1}});
      default: lane_en = '1;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_half
    dbc_half_cmp #(.W(DATA_W)) u_cmp (
      .word    (acc_data[g*DATA_W +: DATA_W]),
      .cmp     (cmp_q),
      .mask    (mask_q),
      .lane_en (lane_en),
      .hit     (half_hit[g])
    );
  end

  // Only the quadword size looks beyond the low half.
  assign data_hit = (size == SZ_QUAD) ? |half_hit : half_hit[0];
  assign cond     = !cmp_en || (acc_has_data && data_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= acc_valid && cond;
  end

  assign brk_match = match_q;
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              cmp_en,
  input logic              acc_valid,
  input logic              acc_has_data,
  input logic              brk_match
);
  a_r9_pulse_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !brk_match);

  a_r7_no_data_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cmp_en && !acc_has_data) |=> !brk_match);

  a_r8_bypass_match: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !cmp_en) |=> brk_match);

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> (reg_sel != $past(reg_sel) || reg_rdata == $past(reg_wdata)));
endmodule

bind data_break_cmp dbc_checker #(.DATA_W(DATA_W)) u_dbc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_en    (reg_wr_en),
  .reg_sel      (reg_sel),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .cmp_en       (cmp_en),
  .acc_valid    (acc_valid),
  .acc_has_data (acc_has_data),
  .brk_match    (brk_match)
);

// File: tb/test_data_break_cmp.sv
module test_data_break_cmp;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        cmp_en = 1'b0, acc_valid = 1'b0, acc_has_data = 1'b0;
  logic [1:0]  acc_size = 2'b00;
  logic [63:0] acc_data = '0;
  logic        brk_match;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  data_break_cmp i_data_break_cmp (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_en(cmp_en),
    .acc_valid(acc_valid), .acc_size(acc_size), .acc_has_data(acc_has_data),
    .acc_data(acc_data), .brk_match(brk_match)
  );

  // Fields: req[135:132] cmp[131:100] mask[99:68] size[67:66] has_data[65] data[64:1] exp[0]
  localparam logic [135:0] VEC [NV] = '{
    {4'd5, 32'h12345678, 32'h00000000, 2'b10, 1'b1, 64'hFFFFFFFF_12345678, 1'b1}, // R5 exact
    {4'd1, 32'h12345678, 32'h00000000, 2'b10, 1'b1, 64'h00000000_12345679, 1'b0}, // R1 bit kept
    {4'd1, 32'h12345678, 32'h00000001, 2'b10, 1'b1, 64'h00000000_12345679, 1'b1}, // R1 bit masked
    {4'd3, 32'hAABBCC78, 32'h00000000, 2'b00, 1'b1, 64'h00000000_00000078, 1'b1}, // R3 byte
    {4'd3, 32'hAABBCC78, 32'h00000000, 2'b00, 1'b1, 64'h00000000_00000079, 1'b0}, // R3 byte miss
    {4'd4, 32'hAABB5678, 32'h00000000, 2'b01, 1'b1, 64'h00000000_FFFF5678, 1'b1}, // R4 word
    {4'd4, 32'hAABB5678, 32'h00000000, 2'b01, 1'b1, 64'h00000000_FFFF5478, 1'b0}, // R4 word miss
    {4'd5, 32'h12345678, 32'h00000000, 2'b10, 1'b1, 64'h12345678_00000000, 1'b0}, // R5 upper ignored
    {4'd6, 32'h12345678, 32'h00000000, 2'b11, 1'b1, 64'h12345678_00000000, 1'b1}, // R6 upper half
    {4'd6, 32'h12345678, 32'h00000000, 2'b11, 1'b1, 64'h00000000_12345678, 1'b1}, // R6 lower half
    {4'd6, 32'h12345678, 32'h00000000, 2'b11, 1'b1, 64'h00000001_00000002, 1'b0}, // R6 neither
    {4'd6, 32'h12345678, 32'hFFFFFF00, 2'b11, 1'b1, 64'h00000078_00000000, 1'b1}, // R6 + R1 mask
    {4'd7, 32'h12345678, 32'h00000000, 2'b10, 1'b0, 64'h00000000_12345678, 1'b0}  // R7 no data
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [31:0] val);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // Strobe one access; result is sampled on the negedge after the capturing posedge.
  task automatic access(input logic [1:0] sz, input logic hd, input logic [63:0] d,
                        output logic res);
    @(negedge clk);
    acc_valid = 1'b1; acc_size = sz; acc_has_data = hd; acc_data = d;
    @(negedge clk);
    acc_valid = 1'b0;
    res = brk_match;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic r;
    repeat (3) @(negedge clk);
    check("R9 reset", {31'b0, brk_match}, 32'd0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wr_reg(1'b0, VEC[i][131:100]);
      wr_reg(1'b1, VEC[i][99:68]);
      reg_sel = 1'b0; #1;
      check("R2 cmp readback", reg_rdata, VEC[i][131:100]);
      reg_sel = 1'b1; #1;
      check("R2 mask readback", reg_rdata, VEC[i][99:68]);
      access(VEC[i][67:66], VEC[i][65], VEC[i][64:1], r);
      check($sformatf("R%0d vector %0d", VEC[i][135:132], i), {31'b0, r}, {31'b0, VEC[i][0]});
    end

    // R9: pulse lasts one cycle
    wr_reg(1'b1, 32'h0);
    wr_reg(1'b0, 32'hCAFE0001);
    access(2'b10, 1'b1, 64'hCAFE0001, r);
    check("R9 pulse", {31'b0, r}, 32'd1);
    @(negedge clk);
    check("R9 single cycle", {31'b0, brk_match}, 32'd0);

    // R8: disabled -> always match, even without data and on mismatch
    cmp_en = 1'b0;
    access(2'b10, 1'b0, 64'h0, r);
    check("R8 bypass no data", {31'b0, r}, 32'd1);
    access(2'b00, 1'b1, 64'h55, r);
    check("R8 bypass mismatch", {31'b0, r}, 32'd1);
    cmp_en = 1'b1;

    // R10: write and strobe in the same cycle
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0BADF00D;
    acc_valid = 1'b1; acc_size = 2'b10; acc_has_data = 1'b1; acc_data = 64'hCAFE0001;
    @(negedge clk);
    reg_wr_en = 1'b0; acc_valid = 1'b0;
    check("R10 old value used", {31'b0, brk_match}, 32'd1);
    access(2'b10, 1'b1, 64'h0BADF00D, r);
    check("R10 new value next", {31'b0, r}, 32'd1);
    access(2'b10, 1'b1, 64'hCAFE0001, r);
    check("R10 old value gone", {31'b0, r}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule